// File: doc/BRIEF.md
# Two-Wire Configuration Memory Read Controller

This block is the target side of a two-wire serial configuration memory. An external programmer drives a clock line and shares an open-drain data line with the block. Through that bus it can read the internal byte array in three ways: from the current pointer, from an address it supplies (random read), or as a continuous stream in which it acknowledges each byte (sequential read). It can also fill the array one page at a time. A reserved high address returns two fixed identification bytes. The bus is only live while the `stream_mode` input is low, which selects programming mode.

Every byte on the wire, including the control byte, the address bytes, the data and the identification codes, travels least significant bit first. A transaction opens with a start condition and a control byte. The control byte holds the read flag in bit 0 and the 7-bit target code `DEV_ID` in bits 7:1. A write or random read then sends three address bytes, low byte first. After them a write continues with data bytes. A random read continues with a repeated start and a control byte with the read flag set. The array is a register array of `2**AW` bytes with no reset. A separate copy of byte 0 is captured whenever reset is held, and reads of address 0 return that copy.

The bus lines pass through a two-flop synchronizer, so the bus must run well below the system clock.

Top module: `cfgmem_twowire_slave`

## Requirements
- R1: While `stream_mode` is high the block never pulls the data line, acknowledges nothing and leaves the memory and the pointer unchanged.
- R2: Bits are taken and sent LSB first. A control byte whose bits 7:1 differ from `DEV_ID` is not acknowledged, and the block then ignores the bus until the next start. The block changes its data-line drive only while the clock line is low.
- R3: A random read returns the byte at the supplied 24-bit address. The random read is a control byte with bit 0 = 0, three address bytes sent low byte first, a repeated start, then a control byte with bit 0 = 1.
- R4: A read control byte sent with no address phase returns the byte that follows the last byte loaded for output.
- R5: Each byte the master acknowledges is followed at once by the byte at the next address.
- R6: After the byte at address `2**AW-1` has been acknowledged, the next byte comes from address 0.
- R7: Address 0x040000 returns 0x1E. Continuing the read returns 0xF7, and further acknowledged bytes alternate between the two codes. Address 0x040001 returns 0xF7.
- R8: Data bytes in a write go to consecutive addresses, wrapping inside the aligned `2**PW`-byte page. Addresses other than the two identification addresses are reduced to their low `AW` bits. Writes while the identification address is selected are discarded.
- R9: Reads of address 0 return the value that address held the last time reset was asserted. A later write to address 0 shows up only after the next reset.
- R10: A byte that is not acknowledged ends the read. The block releases the data line and, after the stop, stays released.
- R11: A start condition in the middle of any transfer abandons it, and the block expects a new control byte.
- R12: The block pulls the data line low during the ninth clock of every control, address and data byte it accepts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also captures the byte-0 read copy |
| stream_mode | input | 1 | High: bus disabled; low: programming mode |
| scl_i | input | 1 | Bus clock from the programmer |
| sda_i | input | 1 | Sensed level of the shared data line |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The case that is hardest to reach from the ports is the byte-0 read copy. It can only be seen by writing address 0 and then reading it before and after a reset pulse, while the rest of the array survives the reset. The bench therefore fills every page, pulses reset, reads address 0 back through a random read, rewrites page 0, and repeats the read around a second reset. Wrap-around needs a sequential read that starts two bytes below the top of the array. Page wrap needs a write that starts in the middle of a page, with the data read back from the page base.

// File: rtl/cfgmem_twowire_slave.sv
`timescale 1ns/1ps
module cfgmem_twowire_slave #(
  parameter int          AW       = 5,
  parameter int          PW       = 2,
  parameter logic [6:0]  DEV_ID   = 7'h50,
  parameter logic [23:0] ID_BASE  = 24'h040000,
  parameter logic [7:0]  MFR_CODE = 8'h1E,
  parameter logic [7:0]  DEV_CODE = 8'hF7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stream_mode,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_TX} st_t;

  logic scl_m, scl_s, scl_p, sda_m, sda_s, sda_p;
  st_t        state;
  logic [3:0] bitcnt;
  logic [2:0] role;
  logic [7:0] shreg, txreg, cache0, rd_byte;
  logic [15:0] abuf;
  logic       drv, mack, rd_req, id_mode, id_sel;
  logic [AW-1:0] ptr;
  logic [PW-1:0] pg_nxt;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, scl_p, sda_m, sda_s, sda_p} <= '1;
    else begin
      {scl_m, scl_s, scl_p} <= {scl_i, scl_m, scl_s};
      {sda_m, sda_s, sda_p} <= {sda_i, sda_m, sda_s};
    end

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire [23:0] addr_full = {shreg, abuf};
  wire id_hit = addr_full[23:1] == ID_BASE[23:1];

  assign pg_nxt   = ptr[PW-1:0] + 1'b1;
  assign rd_byte  = id_mode ? (id_sel ? DEV_CODE : MFR_CODE)
                            : (ptr == '0 ? cache0 : mem[ptr]);
  assign sda_pull = drv;

  wire byte_end = !stream_mode && scl_fall && bitcnt == 4'd8;
  wire wr_en    = byte_end && state == S_RX && role == 3'd4 && !id_mode;
  wire tx_load  = !stream_mode && scl_fall && bitcnt == 4'd9 &&
                  ((state == S_RX && rd_req) || (state == S_TX && mack));

  always_ff @(posedge clk)
    if (wr_en) mem[ptr] <= shreg;

  always_ff @(posedge clk)
    if (!rst_n) cache0 <= mem[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; role <= '0; shreg <= '0; abuf <= '0;
      txreg <= '0; drv <= 1'b0; mack <= 1'b0; rd_req <= 1'b0;
      ptr <= '0; id_mode <= 1'b0; id_sel <= 1'b0;
    end else begin
      if (stream_mode) begin
        state <= S_IDLE; drv <= 1'b0;
      end else if (start_c) begin
        state <= S_RX; bitcnt <= '0; role <= '0; drv <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; drv <= 1'b0;
      end else if (scl_rise && state != S_IDLE) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state == S_RX) shreg <= {sda_s, shreg[7:1]};
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (state == S_TX) mack <= ~sda_s;
        end
      end else if (scl_fall && state == S_RX) begin
        if (bitcnt == 4'd8) begin
          drv <= 1'b1;
          case (role)
            3'd0: if (shreg[7:1] == DEV_ID) begin
                    rd_req <= shreg[0]; role <= 3'd1;
                  end else begin
                    drv <= 1'b0; state <= S_IDLE;
                  end
            3'd1: begin abuf[7:0]  <= shreg; role <= 3'd2; end
            3'd2: begin abuf[15:8] <= shreg; role <= 3'd3; end
            3'd3: begin
                    role <= 3'd4; id_mode <= id_hit; id_sel <= addr_full[0];
                    ptr <= addr_full[AW-1:0];
                  end
            default: if (!id_mode) ptr <= {ptr[AW-1:PW], pg_nxt};
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0; drv <= 1'b0; rd_req <= 1'b0;
        end
      end else if (scl_fall && state == S_TX) begin
        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) drv <= ~txreg[bitcnt[2:0]];
        else if (bitcnt == 4'd8) drv <= 1'b0;
        else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (!mack) begin state <= S_IDLE; drv <= 1'b0; end
        end
      end
      if (tx_load) begin
        state <= S_TX; txreg <= rd_byte; drv <= ~rd_byte[0];
        if (id_mode) id_sel <= ~id_sel;
        else ptr <= ptr + 1'b1;
      end
    end
  end

  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stream_mode) |-> !sda_pull) else $error("mode quiet");          // R1
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> !scl_s) else $error("drive while clock high");          // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !id_mode && ptr == LAST |=> ptr == '0) else $error("wrap"); // R6
  AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cache0)) else $error("cache changed");       // R9
endmodule

// File: tb/cfgmem_twowire_slave_tb.sv
`timescale 1ns/1ps
module cfgmem_twowire_slave_tb;
  localparam int HP = 10;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, stream_mode, scl, sda_m;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;
  int checks = 0, fails = 0;
  logic [7:0] got [8];
  logic ack;

  cfgmem_twowire_slave u_dut (.clk(clk), .rst_n(rst_n), .stream_mode(stream_mode),
    .scl_i(scl), .sda_i(sda_line), .sda_pull(sda_pull));

  // entries: {address, expected byte}; f(a) = 7a+3
  localparam logic [31:0] RD_TAB [7] = '{
    {24'h000005, 8'd38}, {24'h00001F, 8'd220}, {24'h000000, 8'd3},
    {24'h000010, 8'd115},
    {24'h000045, 8'd38},   // R8 masking to AW bits
    {24'h040000, 8'h1E},   // R7
    {24'h040001, 8'hF7}    // R7
  };

  function automatic logic [7:0] f(input int a); return 8'(7 * a + 3); endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_bit(input logic v, output logic s);
    sda_m = v; hw(HP); scl = 1'b1; hw(HP/2); s = sda_line; hw(HP/2); scl = 1'b0; hw(3);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hw(HP); scl = 1'b1; hw(HP); sda_m = 1'b0; hw(HP); scl = 1'b0; hw(3);
  endtask

  task automatic bstop();
    sda_m = 1'b0; hw(HP); scl = 1'b1; hw(HP); sda_m = 1'b1; hw(HP);
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    logic s;
    for (int i = 0; i < 8; i++) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    a = ~s;
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin bus_bit(1'b1, s); b[i] = s; end
    bus_bit(~mack, s);
  endtask

  task automatic addr_phase(input logic [23:0] a, output logic ok);
    logic k;
    ok = 1'b1;
    bstart();
    send(8'hA0, k); ok &= k;
    for (int i = 0; i < 3; i++) begin send(a[8*i +: 8], k); ok &= k; end
  endtask

  task automatic rd_seq(input logic [23:0] a, input int n);
    logic ok, k;
    addr_phase(a, ok);
    bstart(); send(8'hA1, k);
    check8("R12 read acks", {7'd0, ok & k}, 8'd1);
    for (int i = 0; i < n; i++) recv(i < n - 1, got[i]);
    bstop();
  endtask

  task automatic page_wr(input logic [23:0] a, input logic [31:0] w);
    logic ok, k;
    addr_phase(a, ok);
    for (int i = 0; i < 4; i++) begin send(w[8*i +: 8], k); ok &= k; end
    bstop();
    check8("R12 write acks", {7'd0, ok}, 8'd1);
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0; hw(5); rst_n = 1'b1; hw(5);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; stream_mode = 1'b0; scl = 1'b1; sda_m = 1'b1;
    hw(6); rst_n = 1'b1; hw(4);
    check8("R10 reset released", {7'd0, sda_pull}, 8'd0);

    // R8: pages in descending order, any order allowed
    for (int p = 7; p >= 0; p--)
      page_wr(24'(4 * p), {f(4*p+3), f(4*p+2), f(4*p+1), f(4*p)});
    pulse_reset();

    // R3 table walk (also R7, R8 entries)
    for (int i = 0; i < 7; i++) begin
      rd_seq(RD_TAB[i][31:8], 1);
      check8("R3 table", got[0], RD_TAB[i][7:0]);
    end

    // R5 / R6 sequential across the top
    rd_seq(24'd30, 4);
    check8("R5 seq 30", got[0], f(30));
    check8("R5 seq 31", got[1], f(31));
    check8("R6 wrap to 0", got[2], f(0));
    check8("R6 wrap to 1", got[3], f(1));
    check8("R10 released after stop", {7'd0, sda_line}, 8'd1);

    // R4 current address
    bstart(); send(8'hA1, ack); recv(1'b0, got[0]); bstop();
    check8("R4 current addr", got[0], f(2));

    // R7 identification stream
    rd_seq(24'h040000, 3);
    check8("R7 mfr", got[0], 8'h1E);
    check8("R7 dev", got[1], 8'hF7);
    check8("R7 alternate", got[2], 8'h1E);

    // R8 page wrap starting mid-page
    page_wr(24'd6, {8'hA3, 8'hA2, 8'hA1, 8'hA0});
    rd_seq(24'd4, 4);
    check8("R8 pg 4", got[0], 8'hA2);
    check8("R8 pg 5", got[1], 8'hA3);
    check8("R8 pg 6", got[2], 8'hA0);
    check8("R8 pg 7", got[3], 8'hA1);

    // R2 wrong target code
    bstart(); send(8'h42, ack); bstop();
    check8("R2 bad id nack", {7'd0, ack}, 8'd0);

    // R11 abort mid-address, then a fresh random read
    bstart(); send(8'hA0, ack); send(8'h09, ack);
    rd_seq(24'd9, 1);
    check8("R11 after abort", got[0], f(9));

    // R9 cached byte 0
    page_wr(24'd0, {f(3), f(2), f(1), 8'h55});
    rd_seq(24'd0, 1);
    check8("R9 cache held", got[0], f(0));
    pulse_reset();
    rd_seq(24'd0, 1);
    check8("R9 cache reloaded", got[0], 8'h55);

    // R1 bus ignored in streaming mode
    stream_mode = 1'b1; hw(4);
    bstart(); send(8'hA0, ack);
    check8("R1 no ack", {7'd0, ack}, 8'd0);
    send(8'h08, ack); send(8'h00, ack); send(8'h00, ack); send(8'hEE, ack);
    bstop();
    stream_mode = 1'b0; hw(4);
    rd_seq(24'd8, 1);
    check8("R1 memory untouched", got[0], f(8));

    finish_run();
  end
endmodule